// File: doc/BRIEF.md
# Six-Slot TDM Serial Transmitter

This block sends six 24-bit audio words per frame to an external converter over a single time-division-multiplexed serial line. It runs on a fast system clock. The bit clock comes from outside and is sampled as an ordinary input. A falling edge of the bit clock, once seen, moves the block one bit along the frame. Both outputs then change in the next system-clock cycle, so they are settled well before the following rising edge of the bit clock, which is where the receiver samples.

A frame is 256 bit clocks long and is split into two halves of 128. The frame sync is low for the first half and high for the second, giving a 50% duty square wave. Three 32-bit slots sit at the start of each half, and the last 32 bit clocks of each half are idle. Inside a slot the MSB comes one bit clock after the slot boundary, and the 24 data bits follow.

A producer hands over one set of six words through a ready/valid handshake. The block holds that set as pending until the next frame start, then moves it into the set being sent. If no new set has arrived by the frame start, the previous words are sent again and an underrun flag is raised for that frame.

Top module: `tdm6_tx`

## Requirements
- R1: While `rst_n` is low and after its release until the first bit-clock falling edge, `tdm_fs`, `tdm_sd` and `underrun` are 0 and `s_ready` is 1.
- R2: The first bit-clock falling edge seen after reset begins bit 0 of a frame. Each further falling edge advances one bit, and bit 255 wraps to bit 0. `tdm_fs` is 0 for bits 0 to 127 and 1 for bits 128 to 255.
- R3: Slots 0, 1 and 2 start at bits 0, 32 and 64. Slots 3, 4 and 5 start at bits 128, 160 and 192. Bits 96 to 127 and 224 to 255 send 0.
- R4: At offset 0 within a slot `tdm_sd` is 0. Offsets 1 to 24 carry word bits 23 down to 0 (MSB first). Offsets 25 to 31 are 0.
- R5: `tdm_fs` and `tdm_sd` change only in the system-clock cycle after the one in which `bclk` is first sampled low following a high sample. They hold steady across the rising edge of the bit clock and until the next falling edge.
- R6: `s_data` packs slot i in bits [24*i+23 : 24*i], with slot 0 in the least significant 24 bits. A set is accepted on a clock edge where `s_valid` and `s_ready` are both 1.
- R7: After a set is accepted, `s_ready` stays 0 until the next frame start. An offer made during that time is not taken, and the pending set is not replaced.
- R8: At each frame start (the edge that begins bit 0), a pending set becomes the set being sent and `underrun` goes to 0. If nothing is pending, the previous set is sent again and `underrun` goes to 1. `underrun` changes only at frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock, synchronous to clk and at least four clk periods long |
| s_valid | input | 1 | Producer offers a set of six words |
| s_ready | output | 1 | Block can take a set |
| s_data | input | 144 | Six packed 24-bit words, slot 0 in the low bits |
| tdm_fs | output | 1 | Frame sync, low for the first half of the frame and high for the second |
| tdm_sd | output | 1 | Serial data, MSB first, delayed one bit after each slot boundary |
| underrun | output | 1 | High for a frame that repeats the previous words |

## Verification
A bit counter that is off by even one bit shows up right away. The frame sync flips at the wrong bit, and every word arrives shifted, so the stream fails within the first slot. A word-register or handshake fault shows up as wrong data bits in the slot's first frame, or as an `underrun` flag at the wrong value as soon as the next frame starts. Checking every bit of five frames, including a frame that repeats its words and a refused second offer, therefore catches such faults within one frame of the point where they arise.

// File: rtl/tdm6_tx_pkg.sv
package tdm6_tx_pkg;
    localparam int DEF_WORD_W    = 24;
    localparam int DEF_SLOT_W    = 32;
    localparam int DEF_NUM_SLOTS = 6;
    localparam int DEF_FRAME_LEN = 256;
endpackage

// File: rtl/tdm6_bit_timer.sv
module tdm6_bit_timer #(
    parameter  int FRAME_LEN = tdm6_tx_pkg::DEF_FRAME_LEN,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    output logic             fall_o,
    output logic             frame_start_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic             bclk_prev;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.bclk_prev = bclk_i;
        fall_o        = s_q.bclk_prev && !bclk_i;
        cnt_next_o    = (s_q.cnt == CNT_W'(FRAME_LEN - 1)) ? '0 : s_q.cnt + CNT_W'(1);
        if (fall_o) begin
            s_d.cnt = cnt_next_o;
        end
        frame_start_o = fall_o && (cnt_next_o == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bclk_prev <= 1'b0;
            s_q.cnt       <= CNT_W'(FRAME_LEN - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/tdm6_sample_store.sv
module tdm6_sample_store #(
    parameter  int WORD_W    = tdm6_tx_pkg::DEF_WORD_W,
    parameter  int NUM_SLOTS = tdm6_tx_pkg::DEF_NUM_SLOTS,
    localparam int SET_W     = WORD_W * NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    input  logic [SET_W-1:0] s_data_i,
    output logic [SET_W-1:0] words_o,
    output logic             underrun_o
);
    typedef struct packed {
        logic             pend_full;
        logic [SET_W-1:0] pend;
        logic [SET_W-1:0] active;
        logic             underrun;
    } store_t;

    store_t s_d, s_q;

    assign s_ready_o = !s_q.pend_full;

    always_comb begin
        s_d = s_q;
        if (frame_start_i) begin
            if (s_q.pend_full) begin
                s_d.active    = s_q.pend;
                s_d.pend_full = 1'b0;
                s_d.underrun  = 1'b0;
            end else begin
                s_d.underrun  = 1'b1;
            end
        end
        if (s_valid_i && s_ready_o) begin
            s_d.pend      = s_data_i;
            s_d.pend_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign words_o    = s_q.active;
    assign underrun_o = s_q.underrun;

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && s_ready_o) |=> !s_ready_o); // R7
    AST_UNDERRUN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(underrun_o)); // R8
endmodule

// File: rtl/tdm6_slot_serializer.sv
module tdm6_slot_serializer #(
    parameter  int WORD_W    = tdm6_tx_pkg::DEF_WORD_W,
    parameter  int SLOT_W    = tdm6_tx_pkg::DEF_SLOT_W,
    parameter  int NUM_SLOTS = tdm6_tx_pkg::DEF_NUM_SLOTS,
    parameter  int FRAME_LEN = tdm6_tx_pkg::DEF_FRAME_LEN,
    localparam int CNT_W     = $clog2(FRAME_LEN),
    localparam int SET_W     = WORD_W * NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [SET_W-1:0] words_i,
    output logic             fs_o,
    output logic             sd_o
);
    localparam int HALF_LEN = FRAME_LEN / 2;
    localparam int SPH      = NUM_SLOTS / 2;
    localparam int USED_LEN = SPH * SLOT_W;
    localparam int SEL_W    = $clog2(NUM_SLOTS + 1);
    localparam int BIT_W    = $clog2(WORD_W);

    logic [WORD_W-1:0] word_arr [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign word_arr[g] = words_i[g*WORD_W +: WORD_W];
    end

    typedef struct packed {
        logic fs;
        logic sd;
    } ser_t;

    ser_t s_d, s_q;

    logic             upper;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] offs;
    logic [CNT_W-1:0] slot_sel;
    logic [SEL_W-1:0] slot_idx;
    logic [BIT_W-1:0] bit_idx;
    logic             bit_val;

    always_comb begin
        upper    = (cnt_next_i >= CNT_W'(HALF_LEN));
        pos      = upper ? cnt_next_i - CNT_W'(HALF_LEN) : cnt_next_i;
        offs     = pos % CNT_W'(SLOT_W);
        slot_sel = pos / CNT_W'(SLOT_W) + (upper ? CNT_W'(SPH) : '0);
        slot_idx = SEL_W'(slot_sel);
        bit_idx  = BIT_W'(CNT_W'(WORD_W) - offs);
        bit_val  = 1'b0;
        if ((pos < CNT_W'(USED_LEN)) && (offs >= CNT_W'(1)) && (offs <= CNT_W'(WORD_W))) begin
            bit_val = word_arr[slot_idx][bit_idx];
        end
        s_d = s_q;
        if (fall_i) begin
            s_d.fs = upper;
            s_d.sd = bit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fs_o = s_q.fs;
    assign sd_o = s_q.sd;
endmodule

// File: rtl/tdm6_tx.sv
module tdm6_tx #(
    parameter  int WORD_W    = tdm6_tx_pkg::DEF_WORD_W,
    parameter  int SLOT_W    = tdm6_tx_pkg::DEF_SLOT_W,
    parameter  int NUM_SLOTS = tdm6_tx_pkg::DEF_NUM_SLOTS,
    parameter  int FRAME_LEN = tdm6_tx_pkg::DEF_FRAME_LEN,
    localparam int SET_W     = WORD_W * NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [SET_W-1:0] s_data,
    output logic             tdm_fs,
    output logic             tdm_sd,
    output logic             underrun
);
    localparam int CNT_W = $clog2(FRAME_LEN);

    logic             bclk_fall;
    logic             frame_start;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] cnt_q;
    logic [SET_W-1:0] words;

    tdm6_bit_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk),
        .fall_o(bclk_fall), .frame_start_o(frame_start),
        .cnt_next_o(cnt_next), .cnt_o(cnt_q)
    );

    tdm6_sample_store #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
        .words_o(words), .underrun_o(underrun)
    );

    tdm6_slot_serializer #(
        .WORD_W(WORD_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .FRAME_LEN(FRAME_LEN)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .fall_i(bclk_fall), .cnt_next_i(cnt_next),
        .words_i(words), .fs_o(tdm_fs), .sd_o(tdm_sd)
    );

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> ($stable(tdm_fs) && $stable(tdm_sd))); // R5
    AST_FS_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdm_fs) |-> (cnt_q == CNT_W'(FRAME_LEN / 2))); // R2
    AST_FS_FALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tdm_fs) |-> (cnt_q == '0)); // R2
    AST_SLOT_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |=> (((cnt_q & CNT_W'(SLOT_W - 1)) == '0) -> !tdm_sd)); // R4
endmodule

// File: tb/tdm6_tx_test.sv
module tdm6_tx_test;
    localparam int W = 24;
    localparam int N = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bclk = 1'b1;
    logic           s_valid = 1'b0;
    logic [W*N-1:0] s_data = '0;
    logic           s_ready, tdm_fs, tdm_sd, underrun;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur [N];
    logic [W-1:0] pend [N];
    bit pend_full = 0;
    bit exp_under = 0;

    always #2 clk = ~clk;

    tdm6_tx uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .tdm_fs(tdm_fs), .tdm_sd(tdm_sd), .underrun(underrun)
    );

    function automatic logic [W-1:0] word_of(int set, int slot);
        logic [31:0] v;
        v = 32'((set + 1) * 32'h0013_579B * (slot + 3)) ^ 32'((set * 5 + slot) << 7);
        if (slot == 0) v = v | 32'h0080_0001;
        if (slot == 5) v = v & 32'h007F_FFFE;
        return v[W-1:0];
    endfunction

    function automatic logic exp_sd(int k);
        int pos, s, p, slot;
        pos = k % 128;
        s = pos / 32;
        p = pos % 32;
        if (s == 3 || p < 1 || p > 24) return 1'b0;
        slot = (k / 128) * 3 + s;
        return cur[slot][24 - p];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic offer(int set, output bit took);
        @(negedge clk);
        s_valid = 1'b1;
        for (int i = 0; i < N; i++) s_data[i*W +: W] = word_of(set, i);
        took = s_ready;
        @(negedge clk);
        s_valid = 1'b0;
        if (took) begin
            for (int i = 0; i < N; i++) pend[i] = word_of(set, i);
            pend_full = 1;
        end
    endtask

    task automatic run_bit(int k);
        @(negedge clk);
        bclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        check(tdm_fs == (k >= 128), "R2", $sformatf("fs bit %0d", k), int'(tdm_fs), int'(k >= 128));
        check(tdm_sd == exp_sd(k), (k % 128 >= 96) ? "R3" : "R4",
              $sformatf("sd bit %0d", k), int'(tdm_sd), int'(exp_sd(k)));
        @(negedge clk);
        check(tdm_fs == (k >= 128) && tdm_sd == exp_sd(k), "R5",
              $sformatf("hold bit %0d", k), int'({tdm_fs, tdm_sd}), int'({k >= 128, exp_sd(k)}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit took;
        for (int i = 0; i < N; i++) cur[i] = '0;
        repeat (3) @(negedge clk);
        check(!tdm_fs && !tdm_sd && !underrun && s_ready, "R1", "reset outputs",
              int'({tdm_fs, tdm_sd, underrun, s_ready}), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tdm_fs && !tdm_sd && !underrun && s_ready, "R1", "idle outputs",
              int'({tdm_fs, tdm_sd, underrun, s_ready}), 1);
        offer(0, took);
        check(took, "R6", "first offer taken", int'(took), 1);
        for (int f = 0; f < 5; f++) begin
            if (pend_full) begin
                cur = pend;
                pend_full = 0;
                exp_under = 0;
            end else begin
                exp_under = 1;
            end
            for (int k = 0; k < 256; k++) begin
                run_bit(k);
                if (k == 1) check(underrun == exp_under, "R8", $sformatf("underrun frame %0d", f),
                                  int'(underrun), int'(exp_under));
                if (k == 100 && (f == 0 || f == 2 || f == 3)) begin
                    check(s_ready, "R7", $sformatf("ready after frame start %0d", f), int'(s_ready), 1);
                    offer(f == 0 ? 1 : f, took);
                    check(took, "R6", $sformatf("offer frame %0d", f), int'(took), 1);
                end
                if (k == 150 && f == 2) begin
                    offer(3, took);
                    check(!took, "R7", "second offer refused", int'(took), 0);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule